// File: doc/BRIEF.md
# Flash High-Voltage Program/Erase Sequencer

This block steps an embedded flash array through the control sequence needed to program one row or erase one page. A host pulses `start_i` for one cycle with an operation code on `op_i`. The sequencer then raises the matching mode line, waits a setup interval, and turns on the high-voltage enable. It holds both for the active interval, drops the mode line while high voltage remains on for a hold interval, and then turns high voltage off. It finishes with a recovery interval, after which normal reads of the array may resume.

Every interval is a whole number of clock cycles, computed at elaboration as ceil(`CLK_HZ` × time), with a floor of one cycle. Page erase has two durations: a 1 ms erase for parts erased fewer than about a thousand times, and a 4 ms erase for long endurance. While the sequence runs, the block raises a request to mask interrupts. An abort input cuts high voltage at once. The recovery interval still follows the abort, and the block then reports done with an error flag. The host must keep other bus traffic away from the array while the block is busy.

Top module: `flash_hv_seq`

## Requirements
- R1: During and right after synchronous reset, every output is 0 and the block is idle.
- R2: With op code 2'b00 (program), `pgm_o` is high alone for the setup time (10 µs). Then `pgm_o` and `hven_o` are high together for the program setup time (5 µs) plus the program pulse time (30 µs). Then `hven_o` is high alone for the hold time (5 µs). Then all control lines are low for the recovery time (1 µs). `hven_o` never rises unless a mode line was high in the previous cycle.
- R3: With op code 2'b01 (short erase), the same order applies with `ers_o` in place of `pgm_o`. The interval with both `ers_o` and `hven_o` high lasts 1 ms. `pgm_o` and `ers_o` are never high together.
- R4: With op code 2'b10 (long erase), the interval with both `ers_o` and `hven_o` high lasts 4 ms. Every other interval matches R3.
- R5: `busy_o` is high from the cycle after `start_i` is accepted through the last recovery cycle. `irq_mask_o` equals `busy_o` in every cycle.
- R6: While busy, `start_i` has no effect, whatever `op_i` holds. In idle, a start with op code 2'b11 is ignored and `busy_o` stays low.
- R7: `done_o` is a one-cycle pulse in the first cycle after `busy_o` falls. In that cycle all control lines are low, and `err_o` is 0 when no abort was taken.
- R8: An `abort_i` sampled while busy and before recovery clears `pgm_o`, `ers_o` and `hven_o` in the next cycle. A full recovery interval follows, and then `done_o` pulses with `err_o` = 1. `err_o` is never high without `done_o`.
- R9: An abort that lands on the same edge where a phase would advance takes priority, so no later phase begins. An abort sampled in idle or during recovery is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 2 | Operation: 00 program, 01 short erase, 10 long erase, 11 reserved |
| abort_i | input | 1 | Cut high voltage and end the operation early |
| pgm_o | output | 1 | Program mode line to the array |
| ers_o | output | 1 | Erase mode line to the array |
| hven_o | output | 1 | High-voltage enable to the charge pump |
| busy_o | output | 1 | Sequence in progress |
| irq_mask_o | output | 1 | Request that interrupts be masked |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completion was caused by an abort (valid with done_o) |

## Verification
An abort and a phase advance can land on the same clock edge. The bench provokes this with directed operations that raise `abort_i` in the last cycle of the setup, active and hold phases, and also in the first recovery cycle. Every operation is compared sample by sample against a timeline the bench builds from the requirement intervals. At a coinciding edge, the next sample must show all control lines low and recovery started, never the following phase. An abort sampled in recovery must leave `err_o` at 0. Random operations with random abort points and stray starts while busy extend the same comparison.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG      = 2'b00,
        OP_ERS_SHORT = 2'b01,
        OP_ERS_LONG  = 2'b10,
        OP_RSVD      = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HVSET,
        ST_ACTIVE,
        ST_HOLD,
        ST_RECOVER
    } st_e;

    typedef struct packed {
        logic pgm;
        logic ers;
        logic hven;
    } ctl_t;

    // Interval lengths in nanoseconds
    localparam longint unsigned T_NVS_NS       = 64'd10_000;
    localparam longint unsigned T_PGS_NS       = 64'd5_000;
    localparam longint unsigned T_PROG_NS      = 64'd30_000;
    localparam longint unsigned T_NVH_NS       = 64'd5_000;
    localparam longint unsigned T_RCV_NS       = 64'd1_000;
    localparam longint unsigned T_ERS_SHORT_NS = 64'd1_000_000;
    localparam longint unsigned T_ERS_LONG_NS  = 64'd4_000_000;

    function automatic int unsigned cyc_of(longint unsigned clk_hz, longint unsigned ns);
        longint unsigned r;
        r = (clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        if (r < 64'd1) r = 64'd1;
        return int'(r);
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val - 1'b1;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);

    AST_TMR_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));  // R2

    AST_TMR_RELOAD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> !(cnt_q > $past(cnt_q)));  // R2
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned N_NVS   = 1,
    parameter int unsigned N_PGS   = 1,
    parameter int unsigned N_PROG  = 1,
    parameter int unsigned N_NVH   = 1,
    parameter int unsigned N_RCV   = 1,
    parameter int unsigned N_ERS_S = 1,
    parameter int unsigned N_ERS_L = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic             abort_i,
    input  logic             tmr_last,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output ctl_t             ctl_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);
    st_e  state_q, state_d;
    op_e  op_q;
    logic abort_q, abort_take, accept, done_d;

    assign accept     = (state_q == ST_IDLE) && start_i && (op_e'(op_i) != OP_RSVD);
    assign abort_take = abort_i && (state_q != ST_IDLE) && (state_q != ST_RECOVER);

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = CNT_W'(N_RCV);
        done_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                state_d  = ST_SETUP;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(N_NVS);
            end
            ST_RECOVER: if (tmr_last) begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
            end
            default: begin
                if (abort_take) begin
                    state_d  = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(N_RCV);
                end else if (tmr_last) begin
                    tmr_load = 1'b1;
                    case (state_q)
                        ST_SETUP: begin
                            if (op_q == OP_PROG) begin
                                state_d = ST_HVSET;
                                tmr_val = CNT_W'(N_PGS);
                            end else begin
                                state_d = ST_ACTIVE;
                                tmr_val = (op_q == OP_ERS_LONG) ? CNT_W'(N_ERS_L)
                                                                : CNT_W'(N_ERS_S);
                            end
                        end
                        ST_HVSET: begin
                            state_d = ST_ACTIVE;
                            tmr_val = CNT_W'(N_PROG);
                        end
                        ST_ACTIVE: begin
                            state_d = ST_HOLD;
                            tmr_val = CNT_W'(N_NVH);
                        end
                        default: begin
                            state_d = ST_RECOVER;
                            tmr_val = CNT_W'(N_RCV);
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_PROG;
            abort_q <= 1'b0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_o  <= done_d;
            err_o   <= done_d && abort_q;
            if (accept) begin
                op_q    <= op_e'(op_i);
                abort_q <= 1'b0;
            end else if (abort_take) begin
                abort_q <= 1'b1;
            end
        end
    end

    logic mode_on;
    assign mode_on     = (state_q == ST_SETUP) || (state_q == ST_HVSET) || (state_q == ST_ACTIVE);
    assign ctl_o.pgm   = mode_on && (op_q == OP_PROG);
    assign ctl_o.ers   = mode_on && (op_q != OP_PROG);
    assign ctl_o.hven  = (state_q == ST_HVSET) || (state_q == ST_ACTIVE) || (state_q == ST_HOLD);
    assign busy_o      = (state_q != ST_IDLE);

    AST_HV_AFTER_MODE: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_o.hven) |-> $past(ctl_o.pgm || ctl_o.ers));  // R2

    AST_SINGLE_MODE: assert property (@(posedge clk) disable iff (rst)
        !(ctl_o.pgm && ctl_o.ers));  // R3

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);  // R7

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(busy_o) && !busy_o));  // R7

    AST_OP_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(op_q));  // R6

    AST_ABORT_CUTS_HV: assert property (@(posedge clk) disable iff (rst)
        (abort_i && busy_o && state_q != ST_RECOVER) |=>
            (!ctl_o.hven && !ctl_o.pgm && !ctl_o.ers && busy_o));  // R8

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);  // R8
endmodule

// File: rtl/flash_hv_seq.sv
module flash_hv_seq
    import flash_seq_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 64'd50_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [1:0] op_i,
    input  logic       abort_i,
    output logic       pgm_o,
    output logic       ers_o,
    output logic       hven_o,
    output logic       busy_o,
    output logic       irq_mask_o,
    output logic       done_o,
    output logic       err_o
);
    localparam int unsigned N_NVS   = cyc_of(CLK_HZ, T_NVS_NS);
    localparam int unsigned N_PGS   = cyc_of(CLK_HZ, T_PGS_NS);
    localparam int unsigned N_PROG  = cyc_of(CLK_HZ, T_PROG_NS);
    localparam int unsigned N_NVH   = cyc_of(CLK_HZ, T_NVH_NS);
    localparam int unsigned N_RCV   = cyc_of(CLK_HZ, T_RCV_NS);
    localparam int unsigned N_ERS_S = cyc_of(CLK_HZ, T_ERS_SHORT_NS);
    localparam int unsigned N_ERS_L = cyc_of(CLK_HZ, T_ERS_LONG_NS);
    localparam int unsigned N_MAX   = max2(max2(max2(N_NVS, N_PGS), max2(N_PROG, N_NVH)),
                                           max2(N_RCV, max2(N_ERS_S, N_ERS_L)));
    localparam int unsigned CNT_W   = $clog2(N_MAX + 1);

    logic             tmr_load, tmr_last;
    logic [CNT_W-1:0] tmr_val;
    ctl_t             ctl;

    flash_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    flash_seq_ctrl #(
        .CNT_W   (CNT_W),
        .N_NVS   (N_NVS),
        .N_PGS   (N_PGS),
        .N_PROG  (N_PROG),
        .N_NVH   (N_NVH),
        .N_RCV   (N_RCV),
        .N_ERS_S (N_ERS_S),
        .N_ERS_L (N_ERS_L)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .op_i     (op_i),
        .abort_i  (abort_i),
        .tmr_last (tmr_last),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .ctl_o    (ctl),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .err_o    (err_o)
    );

    assign pgm_o      = ctl.pgm;
    assign ers_o      = ctl.ers;
    assign hven_o     = ctl.hven;
    assign irq_mask_o = busy_o;

    AST_MASK_WHOLE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (hven_o || pgm_o || ers_o) |-> irq_mask_o);  // R5
endmodule

// File: tb/test_flash_hv_seq.sv
module test_flash_hv_seq;
    // 1 MHz design clock parameter keeps intervals short: 1 cycle per microsecond
    localparam int E_NVS  = 10;
    localparam int E_PGS  = 5;
    localparam int E_PROG = 30;
    localparam int E_NVH  = 5;
    localparam int E_RCV  = 1;
    localparam int E_ERSS = 1000;
    localparam int E_ERSL = 4000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [1:0] op_i = 2'b00;
    logic abort_i = 1'b0;
    logic pgm_o, ers_o, hven_o, busy_o, irq_mask_o, done_o, err_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    flash_hv_seq #(.CLK_HZ(64'd1_000_000)) i_flash_hv_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .abort_i(abort_i),
        .pgm_o(pgm_o), .ers_o(ers_o), .hven_o(hven_o), .busy_o(busy_o),
        .irq_mask_o(irq_mask_o), .done_o(done_o), .err_o(err_o)
    );

    function automatic logic [6:0] outs();
        return {pgm_o, ers_o, hven_o, busy_o, irq_mask_o, done_o, err_o};
    endfunction

    function automatic int act_len(int op);
        if (op == 0) return E_PGS + E_PROG;
        if (op == 1) return E_ERSS;
        return E_ERSL;
    endfunction

    // Expected {pgm,ers,hven,busy,irq,done,err} at sample i after acceptance
    function automatic logic [6:0] expect_at(int op, int ab, int i);
        int s, a, h, r, b, cut;
        logic eff, m, e;
        s = E_NVS; a = act_len(op); h = E_NVH; r = E_RCV;
        b = s + a + h + r;
        eff = (ab >= 1) && (ab <= b - r);
        cut = eff ? ab : b - r;
        m = (op == 0);
        e = (op != 0);
        if (i >= 1 && i <= cut) begin
            if (i <= s)          return {m, e, 1'b0, 2'b11, 2'b00};
            else if (i <= s + a) return {m, e, 1'b1, 2'b11, 2'b00};
            else                 return {2'b00, 1'b1, 2'b11, 2'b00};
        end
        if (i > cut && i <= cut + r) return {3'b000, 2'b11, 2'b00};
        if (i == cut + r + 1)        return {3'b000, 2'b00, 1'b1, eff};
        return 7'b0;
    endfunction

    task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Runs one operation; ab = sample index at which abort is raised (0 = none),
    // sp = sample index at which a stray start is raised (0 = none)
    task automatic run_op(string tag, int op, int ab, int sp, logic [1:0] sop);
        int b, len;
        logic ok;
        logic [6:0] first_act, first_exp;
        b = E_NVS + act_len(op) + E_NVH + E_RCV;
        len = b + 3;
        ok = 1'b1;
        first_act = '0; first_exp = '0;
        start_i = 1'b1;
        op_i = op[1:0];
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 1; i <= len; i++) begin
            if (ok && outs() !== expect_at(op, ab, i)) begin
                ok = 1'b0;
                first_act = outs();
                first_exp = expect_at(op, ab, i);
                $display("FAIL %s sample=%0d actual=%b expected=%b", tag, i, first_act, first_exp);
            end
            abort_i = (i == ab);
            if (i == sp) begin
                start_i = 1'b1;
                op_i = sop;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        abort_i = 1'b0;
        start_i = 1'b0;
        total++;
        if (!ok) bad++;
    endtask

    initial begin
        int b_prog;
        void'($urandom(32'd20240611));
        b_prog = E_NVS + E_PGS + E_PROG + E_NVH + E_RCV;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", outs(), 7'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", outs(), 7'b0);

        run_op("R2 program", 0, 0, 0, 2'b00);
        run_op("R3 short erase", 1, 0, 0, 2'b00);
        run_op("R4 long erase", 2, 0, 0, 2'b00);
        run_op("R5 R6 start while busy", 0, 0, 12, 2'b01);
        run_op("R7 start on setup edge ignored", 1, 0, 1, 2'b00);

        run_op("R8 abort in active", 0, E_NVS + 7, 0, 2'b00);
        run_op("R9 abort at setup end", 0, E_NVS, 0, 2'b00);
        run_op("R9 abort at program active end", 0, E_NVS + E_PGS + E_PROG, 0, 2'b00);
        run_op("R9 abort at hold end", 1, E_NVS + E_ERSS + E_NVH, 0, 2'b00);
        run_op("R9 abort in recovery ignored", 0, b_prog, 0, 2'b00);

        // R6: reserved op in idle is ignored
        start_i = 1'b1; op_i = 2'b11;
        @(negedge clk);
        start_i = 1'b0;
        check("R6 reserved op no start", outs(), 7'b0);
        @(negedge clk);
        check("R6 reserved op still idle", outs(), 7'b0);

        // R9: abort while idle is ignored, then a normal operation has no error
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        check("R9 abort in idle", outs(), 7'b0);
        run_op("R7 R9 clean op after idle abort", 0, 0, 0, 2'b00);

        for (int k = 0; k < 16; k++) begin
            int op, b, ab, sp;
            op = (($urandom % 8) == 0) ? 2 : int'($urandom % 2);
            b = E_NVS + act_len(op) + E_NVH + E_RCV;
            ab = (($urandom % 3) == 0) ? 1 + int'($urandom % b) : 0;
            sp = (($urandom % 2) == 0) ? 1 + int'($urandom % (E_NVS + 2)) : 0;
            run_op("R8 random op", op, ab, sp, 2'($urandom));
            repeat (int'($urandom % 3)) @(negedge clk);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<=190000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule